// File: doc/BRIEF.md
# Dual-Enable Character Display Bus Master

This block is the host-side engine for a 40-column, 4-line character display that is built from two controllers. Both controllers share the register-select line, the read/write line and an 8-bit data bus. Each controller has its own enable strobe. The upper controller drives display lines 1 and 2 and the lower one drives lines 3 and 4. A host presents one request at a time. The request carries a half select, a register select, a read/write flag, a data byte, a 4-bit/8-bit mode bit and a poll flag. The engine converts the request into correctly timed enable pulses on the chosen half.

Every timing window comes from a nanoseconds-per-clock parameter: control setup before the enable rises, enable high width, hold after the enable falls, and the gap that satisfies both the enable low width and the minimum cycle time. In 4-bit mode a byte travels as two pulses on the upper four data lines, high nibble first. With the poll flag set, a write first reads the status byte of the targeted half until its top bit (busy) reads 0. If that bit keeps reading 1, a poll limit ends the request with an error. The data bus has a separate output byte and an output-enable for an external tri-state pad.

The control state machine has five states:
- IDLE: waits for a request.
- SETUP: control lines valid, enable low.
- HIGH: enable asserted; read data is sampled on its last cycle.
- HOLD: enable low, control and write data held.
- GAP: fills out the enable low width and the cycle time.

Its transitions are:
- IDLE→SETUP on an accepted request.
- SETUP→HIGH, HIGH→HOLD and HOLD→GAP each when the phase timer expires.
- GAP→SETUP for the next pulse, which can be the second nibble, another poll or the write after a successful poll.
- GAP→IDLE when the transfer is complete.

Top module: `lcd_bus_master`

## Requirements
- R1: While reset is low and right after it, both enables, the bus output-enable, the acknowledge and the error flag are 0, and the ready output is 1.
- R2: A request with half select 0 pulses only the upper enable, and half select 1 pulses only the lower enable. The two enables are never high together.
- R3: With the default 5 ns clock: RS and R/W are stable for at least 8 cycles before an enable rises. An enable stays high for at least 46 cycles. RS and R/W stay unchanged for at least 2 cycles after it falls. Successive enable rises are at least 100 cycles apart.
- R4: An 8-bit write drives the whole byte on the data output with the output-enable at 1 from setup until the end of the hold window. RS and R/W equal the request values.
- R5: A 4-bit write issues two pulses. The first carries data bits 7..4 on bus bits 7..4 and the second carries data bits 3..0 on bus bits 7..4. Bus bits 3..0 are driven 0.
- R6: A read keeps the output-enable at 0 for all its pulses. It returns the byte sampled on the last high cycle: in 8-bit mode the whole bus, in 4-bit mode bus bits 7..4 of the first pulse followed by bus bits 7..4 of the second.
- R7: A write with the poll flag first performs status reads (RS=0, R/W=1) of the same half, two pulses each in 4-bit mode. It repeats them while bus bit 7 of the status byte is 1 and issues the write after the first status that reads 0. The poll flag has no effect on reads.
- R8: If POLL_LIMIT successive status reads all show busy, the write is not issued, the request ends with acknowledge and the error flag set. The next accepted request clears the flag.
- R9: The acknowledge is a one-cycle pulse in the cycle the final enable falls. A request is taken only while ready is 1, and a request offered while the engine is busy produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when ready is 1 |
| req_half | input | 1 | 0 = upper controller, 1 = lower controller |
| req_rs | input | 1 | Register select for the transfer |
| req_rw | input | 1 | 1 = read, 0 = write |
| req_data | input | 8 | Write byte |
| req_nib | input | 1 | 1 = 4-bit transfer in two nibbles |
| req_poll | input | 1 | Poll busy before a write |
| ready | output | 1 | Engine idle |
| ack | output | 1 | Transfer complete pulse |
| rd_data | output | 8 | Last byte read |
| timeout_err | output | 1 | Poll limit reached on last request |
| lcd_rs | output | 1 | Register select to the display |
| lcd_rw | output | 1 | Read/write to the display |
| lcd_e1 | output | 1 | Enable of upper controller |
| lcd_e2 | output | 1 | Enable of lower controller |
| lcd_db_out | output | 8 | Data bus drive value |
| lcd_db_in | input | 8 | Data bus pad input |
| lcd_db_oe | output | 1 | Data bus output-enable |

## Verification
The status read that ends a poll and the decision to issue the write fall in the same edge: the engine leaves the high phase of the last status pulse. Finishing the poll loop and reaching the poll limit can also coincide at that edge. The bench sets the device model's busy count to exactly POLL_LIMIT-1 and to POLL_LIMIT and above. It judges the outcome by counting enable pulses per half, checking whether the write pulse appears, and checking the error flag and single acknowledge.

// File: rtl/lcd_bus_pkg.sv
`timescale 1ns/1ps
package lcd_bus_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_HOLD,
        ST_GAP
    } bus_state_t;

    // clocks needed to cover a span given in nanoseconds
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcd_phase_timer.sv
`timescale 1ns/1ps
module lcd_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/lcd_nibble_lane.sv
`timescale 1ns/1ps
module lcd_nibble_lane
    import lcd_bus_pkg::*;
(
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              nib_mode,
    input  logic              nib_idx,
    input  logic [BYTE_W-1:0] bus_in,
    input  logic [NIB_W-1:0]  hi_saved,
    output logic [BYTE_W-1:0] bus_drive,
    output logic [BYTE_W-1:0] rd_byte
);
    logic [NIB_W-1:0] nib_sel;

    always_comb begin
        nib_sel   = nib_idx ? wr_byte[NIB_W-1:0] : wr_byte[BYTE_W-1:NIB_W];
        bus_drive = nib_mode ? {nib_sel, {NIB_W{1'b0}}} : wr_byte;
        rd_byte   = nib_mode ? {hi_saved, bus_in[BYTE_W-1:NIB_W]} : bus_in;
    end
endmodule

// File: rtl/lcd_bus_master.sv
`timescale 1ns/1ps
module lcd_bus_master
    import lcd_bus_pkg::*;
#(
    parameter int CLK_NS     = 5,
    parameter int T_SU_NS    = 40,
    parameter int T_PW_NS    = 230,
    parameter int T_HOLD_NS  = 10,
    parameter int T_CYC_NS   = 500,
    parameter int T_RD_NS    = 120,
    parameter int POLL_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_half,
    input  logic              req_rs,
    input  logic              req_rw,
    input  logic [BYTE_W-1:0] req_data,
    input  logic              req_nib,
    input  logic              req_poll,
    output logic              ready,
    output logic              ack,
    output logic [BYTE_W-1:0] rd_data,
    output logic              timeout_err,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic              lcd_e1,
    output logic              lcd_e2,
    output logic [BYTE_W-1:0] lcd_db_out,
    input  logic [BYTE_W-1:0] lcd_db_in,
    output logic              lcd_db_oe
);
    localparam int SU_C   = imax(ns_to_cyc(T_SU_NS, CLK_NS), 1);
    localparam int PW_C   = imax(imax(ns_to_cyc(T_PW_NS, CLK_NS),
                                      ns_to_cyc(T_RD_NS, CLK_NS) + 1), 1);
    localparam int HOLD_C = imax(ns_to_cyc(T_HOLD_NS, CLK_NS), 1);
    localparam int GAP_C  = imax(imax(ns_to_cyc(T_PW_NS, CLK_NS) - HOLD_C - SU_C,
                                      ns_to_cyc(T_CYC_NS, CLK_NS) - SU_C - PW_C - HOLD_C), 1);
    localparam int TMAX   = imax(imax(SU_C, PW_C), imax(HOLD_C, GAP_C));
    localparam int TW     = $clog2(TMAX + 1);
    localparam int PCW    = $clog2(POLL_LIMIT + 1);

    bus_state_t state_q, state_d;
    logic              tmr_load, tmr_done;
    logic [TW-1:0]     tmr_val;

    logic              half_q, rs_q, rw_q, nib_q, nib_idx_q;
    logic              polling_q, go_write_q, end_q, ack_q, err_q;
    logic [BYTE_W-1:0] data_q, rd_q;
    logic [NIB_W-1:0]  hi_q;
    logic [PCW-1:0]    poll_cnt_q;

    logic              cur_rs, cur_rw, last_pulse, busy_seen, high_exit, gap_exit;
    logic [BYTE_W-1:0] drive_byte, rd_byte;

    lcd_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    lcd_nibble_lane u_lane (
        .wr_byte   (data_q),
        .nib_mode  (nib_q),
        .nib_idx   (nib_idx_q),
        .bus_in    (lcd_db_in),
        .hi_saved  (hi_q),
        .bus_drive (drive_byte),
        .rd_byte   (rd_byte)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and phase timer load
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE:  if (req_valid) begin
                          state_d = ST_SETUP; tmr_load = 1'b1; tmr_val = TW'(SU_C - 1);
                      end
            ST_SETUP: if (tmr_done) begin
                          state_d = ST_HIGH;  tmr_load = 1'b1; tmr_val = TW'(PW_C - 1);
                      end
            ST_HIGH:  if (tmr_done) begin
                          state_d = ST_HOLD;  tmr_load = 1'b1; tmr_val = TW'(HOLD_C - 1);
                      end
            ST_HOLD:  if (tmr_done) begin
                          state_d = ST_GAP;   tmr_load = 1'b1; tmr_val = TW'(GAP_C - 1);
                      end
            ST_GAP:   if (tmr_done) begin
                          if (end_q) state_d = ST_IDLE;
                          else begin
                              state_d = ST_SETUP; tmr_load = 1'b1; tmr_val = TW'(SU_C - 1);
                          end
                      end
        endcase
    end

    assign last_pulse = !nib_q || nib_idx_q;
    assign busy_seen  = nib_q ? hi_q[NIB_W-1] : lcd_db_in[BYTE_W-1];
    assign high_exit  = (state_q == ST_HIGH) && tmr_done;
    assign gap_exit   = (state_q == ST_GAP) && tmr_done;

    // transfer context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0; rs_q <= 1'b0; rw_q <= 1'b0; nib_q <= 1'b0; nib_idx_q <= 1'b0;
            polling_q <= 1'b0; go_write_q <= 1'b0; end_q <= 1'b0; ack_q <= 1'b0;
            err_q <= 1'b0; data_q <= '0; rd_q <= '0; hi_q <= '0; poll_cnt_q <= '0;
        end else begin
            ack_q <= 1'b0;
            if (state_q == ST_IDLE && req_valid) begin
                half_q     <= req_half;
                rs_q       <= req_rs;
                rw_q       <= req_rw;
                data_q     <= req_data;
                nib_q      <= req_nib;
                nib_idx_q  <= 1'b0;
                polling_q  <= req_poll && !req_rw;
                go_write_q <= 1'b0;
                end_q      <= 1'b0;
                err_q      <= 1'b0;
                poll_cnt_q <= '0;
            end
            if (high_exit) begin
                if (!last_pulse) begin
                    hi_q <= lcd_db_in[BYTE_W-1:NIB_W];
                end else if (polling_q) begin
                    if (busy_seen) begin
                        poll_cnt_q <= poll_cnt_q + 1'b1;
                        if (poll_cnt_q == PCW'(POLL_LIMIT - 1)) begin
                            err_q <= 1'b1;
                            ack_q <= 1'b1;
                            end_q <= 1'b1;
                        end
                    end else begin
                        go_write_q <= 1'b1;
                    end
                end else begin
                    ack_q <= 1'b1;
                    end_q <= 1'b1;
                    if (rw_q) rd_q <= rd_byte;
                end
            end
            if (gap_exit) begin
                if (nib_q) nib_idx_q <= !nib_idx_q;
                if (go_write_q) begin
                    polling_q  <= 1'b0;
                    go_write_q <= 1'b0;
                end
            end
        end
    end

    // outputs
    always_comb begin
        cur_rs      = polling_q ? 1'b0 : rs_q;
        cur_rw      = polling_q ? 1'b1 : rw_q;
        lcd_rs      = cur_rs;
        lcd_rw      = cur_rw;
        lcd_e1      = (state_q == ST_HIGH) && !half_q;
        lcd_e2      = (state_q == ST_HIGH) && half_q;
        lcd_db_out  = drive_byte;
        lcd_db_oe   = !cur_rw && (state_q == ST_SETUP || state_q == ST_HIGH ||
                                  state_q == ST_HOLD);
        ready       = (state_q == ST_IDLE);
        ack         = ack_q;
        rd_data     = rd_q;
        timeout_err = err_q;
    end

    logic e_any;
    assign e_any = lcd_e1 || lcd_e2;

    assert_one_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(lcd_e1 && lcd_e2));
    assert_ctrl_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (e_any && $past(e_any)) |-> ($stable(lcd_rs) && $stable(lcd_rw)));
    assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(e_any) |=> ($stable(lcd_rs) && $stable(lcd_rw)));
    assert_drive_write_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_db_oe |-> !lcd_rw);
    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(e_any) && $past(lcd_db_oe)) |-> (lcd_db_oe && $stable(lcd_db_out)));
    assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    assert_ack_at_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $fell(e_any));
endmodule

// File: tb/tb_lcd_bus_master.sv
`timescale 1ns/1ps
module tb_lcd_bus_master;
    localparam int CLK_NS = 5;
    localparam int LIMIT  = 4;

    function automatic int cyc(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction

    localparam int E_SU   = cyc(40);
    localparam int E_PW   = cyc(230);
    localparam int E_HOLD = cyc(10);
    localparam int E_CYC  = cyc(500);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_half = 1'b0, req_rs = 1'b0, req_rw = 1'b0;
    logic req_nib = 1'b0, req_poll = 1'b0;
    logic [7:0] req_data = 8'h00;
    logic ready, ack, timeout_err, lcd_rs, lcd_rw, lcd_e1, lcd_e2, lcd_db_oe;
    logic [7:0] rd_data, lcd_db_out, lcd_db_in;

    always #2.5 clk = ~clk;

    lcd_bus_master #(.CLK_NS(CLK_NS), .POLL_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_half(req_half),
        .req_rs(req_rs), .req_rw(req_rw), .req_data(req_data), .req_nib(req_nib),
        .req_poll(req_poll), .ready(ready), .ack(ack), .rd_data(rd_data),
        .timeout_err(timeout_err), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
        .lcd_e1(lcd_e1), .lcd_e2(lcd_e2), .lcd_db_out(lcd_db_out),
        .lcd_db_in(lcd_db_in), .lcd_db_oe(lcd_db_oe)
    );

    // display controller model
    logic [6:0] dev_ac [2];
    logic [7:0] dev_dat [2];
    int         busy_left [2];
    logic       dev_nib = 1'b0, dev_phase = 1'b0, tb_half = 1'b0;
    wire  [7:0] dev_byte = lcd_rs ? dev_dat[tb_half] : {busy_left[tb_half] != 0, dev_ac[tb_half]};
    assign lcd_db_in = dev_nib ? (dev_phase ? {dev_byte[3:0], 4'h0} : {dev_byte[7:4], 4'h0})
                               : dev_byte;

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // bus monitor
    localparam int LOGN = 512;
    logic       pl_half [LOGN];
    logic       pl_rs [LOGN];
    logic       pl_rw [LOGN];
    logic       pl_oe [LOGN];
    logic [7:0] pl_db [LOGN];
    int n_pulse = 0, ack_total = 0, ack_off = 0, tim_bad = 0, both_bad = 0, oe_bad = 0;
    int ctrl_age = 0, high_len = 0, since_rise = 1000, hold_age = 1000;
    logic prev_e = 1'b0, prev_e2 = 1'b0;
    logic [1:0] prev_ctrl = 2'b00;

    always @(negedge clk) begin
        if (rst_n) begin
            automatic logic e_any = lcd_e1 | lcd_e2;
            automatic logic fell  = prev_e && !e_any;
            if (lcd_e1 && lcd_e2) both_bad++;
            if (lcd_db_oe && lcd_rw) oe_bad++;
            if ({lcd_rs, lcd_rw} != prev_ctrl) begin
                if (e_any || prev_e || hold_age < E_HOLD) tim_bad++;
                ctrl_age = 0;
            end else ctrl_age++;
            since_rise++;
            if (e_any && !prev_e) begin
                if (ctrl_age < E_SU) tim_bad++;
                if (since_rise < E_CYC) tim_bad++;
                since_rise = 0;
                high_len = 0;
            end
            if (e_any) high_len++;
            if (fell) begin
                automatic int ix = n_pulse % LOGN;
                if (high_len < E_PW) tim_bad++;
                pl_half[ix] = prev_e2; pl_rs[ix] = lcd_rs; pl_rw[ix] = lcd_rw;
                pl_oe[ix] = lcd_db_oe; pl_db[ix] = lcd_db_out;
                n_pulse++;
                hold_age = 0;
                if (lcd_rw) begin
                    if (dev_nib && !dev_phase) dev_phase = 1'b1;
                    else begin
                        dev_phase = 1'b0;
                        if (!lcd_rs && busy_left[tb_half] > 0) busy_left[tb_half]--;
                    end
                end
            end else begin
                hold_age++;
                if (hold_age == E_HOLD - 1 && n_pulse > 0) begin
                    automatic int lx = (n_pulse - 1) % LOGN;
                    if (pl_oe[lx] && (!lcd_db_oe || lcd_db_out != pl_db[lx])) tim_bad++;
                end
            end
            if (ack) begin
                ack_total++;
                if (!fell) ack_off++;
            end
            prev_e = e_any; prev_e2 = lcd_e2; prev_ctrl = {lcd_rs, lcd_rw};
        end
    end

    task automatic do_txn(input logic h, input logic rs, input logic rw, input logic [7:0] d,
                          input logic nib, input logic poll, input int busy_pre, input bit intrude);
        int start, acks0, per, polls, exp_n, wc, got;
        bit do_poll, tmo, ok_half, ok_poll, ok_data, ok_ctl, ok_rdoe;
        logic [7:0] exp_rd, exp_db;
        tb_half = h; dev_nib = nib; dev_phase = 1'b0; busy_left[h] = busy_pre;
        exp_rd = rs ? dev_dat[h] : {busy_pre != 0, dev_ac[h]};
        while (!ready) @(negedge clk);
        start = n_pulse; acks0 = ack_total;
        req_half = h; req_rs = rs; req_rw = rw; req_data = d; req_nib = nib; req_poll = poll;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (intrude) begin
            repeat (20) @(negedge clk);
            req_half = !h; req_data = ~d; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        wc = 0;
        while (!ready && wc < 20000) begin @(negedge clk); wc++; end
        repeat (intrude ? 150 : 2) @(negedge clk);
        per     = nib ? 2 : 1;
        do_poll = poll && !rw;
        tmo     = do_poll && (busy_pre >= LIMIT);
        polls   = !do_poll ? 0 : (tmo ? LIMIT : busy_pre + 1);
        exp_n   = polls * per + (tmo ? 0 : per);
        got     = n_pulse - start;
        chk(got == exp_n, "R7 pulse count", got, exp_n);
        chk(ack_total - acks0 == 1, "R9 one ack", ack_total - acks0, 1);
        chk(timeout_err == tmo, "R8 error flag", timeout_err, tmo);
        ok_half = 1; ok_poll = 1; ok_data = 1; ok_ctl = 1; ok_rdoe = 1;
        for (int i = 0; i < exp_n && i < got; i++) begin
            automatic int ix = (start + i) % LOGN;
            if (pl_half[ix] != h) ok_half = 0;
            if (i < polls * per) begin
                if (pl_rs[ix] || !pl_rw[ix] || pl_oe[ix]) ok_poll = 0;
            end else begin
                automatic int j = i - polls * per;
                if (pl_rs[ix] != rs || pl_rw[ix] != rw) ok_ctl = 0;
                exp_db = nib ? ((j == 0) ? {d[7:4], 4'h0} : {d[3:0], 4'h0}) : d;
                if (!rw && (!pl_oe[ix] || pl_db[ix] != exp_db)) ok_data = 0;
                if (rw && pl_oe[ix]) ok_rdoe = 0;
            end
        end
        chk(ok_half, "R2 half select", ok_half, 1);
        if (do_poll) chk(ok_poll, "R7 status reads", ok_poll, 1);
        if (!tmo) begin
            chk(ok_ctl, "R4 control lines", ok_ctl, 1);
            if (!rw) chk(ok_data, nib ? "R5 nibble data" : "R4 byte data", ok_data, 1);
            else begin
                chk(ok_rdoe, "R6 bus released", ok_rdoe, 1);
                chk(rd_data == exp_rd, "R6 read data", rd_data, exp_rd);
            end
        end
        chk(tim_bad == 0, "R3 timing", tim_bad, 0);
        chk(both_bad == 0 && oe_bad == 0, "R2 exclusive enables / R6 drive", both_bad + oe_bad, 0);
        chk(ack_off == 0, "R9 ack at fall", ack_off, 0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        dev_ac[0] = 7'h13; dev_ac[1] = 7'h52;
        dev_dat[0] = 8'hC6; dev_dat[1] = 8'h3B;
        busy_left[0] = 0; busy_left[1] = 0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(!lcd_e1 && !lcd_e2 && !lcd_db_oe && !ack && !timeout_err && ready,
            "R1 in reset", {lcd_e1, lcd_e2, lcd_db_oe, ack, timeout_err, ready}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!lcd_e1 && !lcd_e2 && !lcd_db_oe && !ack && !timeout_err && ready,
            "R1 after reset", {lcd_e1, lcd_e2, lcd_db_oe, ack, timeout_err, ready}, 1);

        do_txn(0, 1, 0, 8'hA5, 0, 0, 0, 0);      // R4 upper half byte write
        do_txn(1, 0, 0, 8'h38, 0, 0, 0, 0);      // R2 lower half
        do_txn(0, 1, 0, 8'h9C, 1, 0, 0, 0);      // R5 nibble write
        do_txn(1, 1, 1, 8'h00, 0, 0, 0, 0);      // R6 byte read
        do_txn(0, 1, 1, 8'h00, 1, 0, 0, 0);      // R6 nibble read
        do_txn(1, 0, 1, 8'h00, 0, 0, 2, 0);      // R6 status read shows busy
        do_txn(0, 1, 0, 8'h71, 0, 1, 2, 0);      // R7 poll then write
        do_txn(1, 1, 0, 8'h4E, 1, 1, 1, 0);      // R7 nibble poll
        do_txn(0, 0, 0, 8'h01, 0, 1, LIMIT - 1, 0); // R8 boundary: last allowed poll is free
        do_txn(1, 1, 0, 8'hE7, 1, 1, LIMIT + 2, 0); // R8 timeout
        do_txn(0, 1, 0, 8'h12, 0, 0, 0, 0);      // R8 flag cleared
        do_txn(0, 1, 0, 8'hD4, 0, 0, 0, 1);      // R9 request while busy ignored
        do_txn(1, 1, 1, 8'h00, 0, 1, 3, 0);      // R7 poll flag no effect on read

        for (int i = 0; i < 24; i++) begin
            do_txn(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 8'($urandom),
                   1'($urandom % 2), 1'($urandom % 2), int'($urandom % 6), 0);
        end
        finish_run();
    end
endmodule